// File: doc/BRIEF.md
# Guarded Self-Timed Array Programming Sequencer

This block sits between a serial command decoder and a non-volatile storage array. The decoder hands it single-cycle strobes for enable, disable, single-word write, erase-all and write-all, along with an address and a data word. The sequencer keeps a write-permission latch. It accepts programming requests only while that latch is set and the supply is reported good. It then drives the array's write port through a self-timed cycle whose length is derived from a clock frequency parameter and a time budget in microseconds.

A single-word write is split into two phases. The target word is first set to all ones, and the requested data is written after that. Erase-all drives one bulk pulse that sets every word to all ones. Write-all walks every address in ascending order and stores the same word at each one, spreading a total time budget evenly across the words. A busy flag covers the whole cycle, up to and including the last array pulse, and any request that arrives while busy is high is discarded. A drop of the power-good input stops a running cycle at once and withdraws write permission.

Top module: `prog_sequencer`

## Requirements
- R1: After reset the permission latch is clear, busy is low and no array pulse occurs. A write, erase-all or write-all issued before any enable strobe leaves the array unchanged.
- R2: An enable strobe sets the permission latch and a disable strobe clears it. While the latch is clear, write, erase-all and write-all strobes are dropped with no busy period and no array pulse.
- R3: An accepted write produces exactly two array pulses to the requested address. The first carries all ones on the data bus and the second carries the requested data.
- R4: The write time budget is 2000 us when DATA_W is above 8 and 1000 us otherwise, giving WT = CLK_KHZ*budget/1000 ticks. The erase phase takes WT/2 ticks and the data phase takes the rest. Busy stays high for WT+1 clock cycles.
- R5: An accepted erase-all produces a single pulse with the bulk flag high and all ones on the data bus, ET = CLK_KHZ*ERAL_US/1000 ticks after acceptance. Busy stays high for ET+1 cycles.
- R6: An accepted write-all stores the data word at addresses 0 to 2^ADDR_W-1 in ascending order, one pulse per word, each WW = (CLK_KHZ*WRAL_US/1000)/2^ADDR_W ticks (at least 1) after the previous step. Busy stays high for 2^ADDR_W*WW+1 cycles.
- R7: While busy is high, every strobe is ignored, including enable and disable.
- R8: While power-good is low, strobes are ignored. A running cycle is abandoned with no further array pulse, and the permission latch is cleared.
- R9: When several strobes arrive in one cycle, disable wins over enable and erase-all wins over write-all, which wins over write. A programming strobe checks the latch value held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_good_i | input | 1 | Supply above programming threshold |
| cmd_en_i | input | 1 | Enable-programming strobe |
| cmd_dis_i | input | 1 | Disable-programming strobe |
| cmd_wr_i | input | 1 | Single-word write strobe |
| cmd_eral_i | input | 1 | Erase-all strobe |
| cmd_wral_i | input | 1 | Write-all strobe |
| addr_i | input | ADDR_W | Write target address |
| data_i | input | DATA_W | Write or write-all data |
| busy_o | output | 1 | Self-timed cycle in progress |
| arr_we_o | output | 1 | Array write pulse |
| arr_all_o | output | 1 | Pulse applies to every word |
| arr_addr_o | output | ADDR_W | Array word address |
| arr_data_o | output | DATA_W | Array data word |

## Verification
The bench goes after the permission latch at reset, after disable, and after a power dip. A design that powered up enabled or kept the latch through a dip would write to the array where the model expects no change. It issues strobes during busy periods and combined strobes in one cycle. A design that queued requests, or that let enable beat disable, would show an extra pulse or a changed word. It also drops power-good partway through a write and measures the busy length of every operation. A missing erase phase, a wrong tick count or a write-all walking the wrong way shows up as a wrong pulse count, a wrong pulse order or a wrong busy length.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_ERASE,
        ST_WR_PROG,
        ST_ERAL,
        ST_WRAL
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_WRITE,
        OP_ERAL,
        OP_WRAL
    } prog_op_e;

endpackage

// File: rtl/prog_req_arbiter.sv
module prog_req_arbiter
    import prog_seq_pkg::*;
(
    input  logic     accept_i,
    input  logic     wel_i,
    input  logic     en_i,
    input  logic     dis_i,
    input  logic     wr_i,
    input  logic     eral_i,
    input  logic     wral_i,
    output logic     set_o,
    output logic     clr_o,
    output prog_op_e op_o
);

    always_comb begin
        set_o = accept_i & en_i & ~dis_i;
        clr_o = accept_i & dis_i;
        op_o  = OP_NONE;
        if (accept_i && wel_i) begin
            if (eral_i)      op_o = OP_ERAL;
            else if (wral_i) op_o = OP_WRAL;
            else if (wr_i)   op_o = OP_WRITE;
        end
    end

endmodule

// File: rtl/prog_wel_latch.sv
module prog_wel_latch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    input  logic kill_i,
    output logic wel_o
);

    logic wel_d, wel_q;

    always_comb begin
        wel_d = wel_q;
        if (kill_i || clr_i) wel_d = 1'b0;
        else if (set_i)      wel_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) wel_q <= 1'b0;
        else         wel_q <= wel_d;
    end

    assign wel_o = wel_q;

endmodule

// File: rtl/prog_tick_timer.sv
module prog_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)             cnt_d = load_val_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 16,
    parameter int CLK_KHZ = 1000,
    parameter int ERAL_US = 15000,
    parameter int WRAL_US = 15000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pwr_good_i,
    input  logic              cmd_en_i,
    input  logic              cmd_dis_i,
    input  logic              cmd_wr_i,
    input  logic              cmd_eral_i,
    input  logic              cmd_wral_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic              arr_all_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_data_o
);

    localparam int DEPTH    = 1 << ADDR_W;
    localparam int WR_US    = (DATA_W > 8) ? 2000 : 1000;
    localparam int WR_RAW   = CLK_KHZ * WR_US / 1000;
    localparam int WR_T     = (WR_RAW < 2) ? 2 : WR_RAW;
    localparam int ERASE_T  = WR_T / 2;
    localparam int PROG_T   = WR_T - ERASE_T;
    localparam int ERAL_RAW = CLK_KHZ * ERAL_US / 1000;
    localparam int ERAL_T   = (ERAL_RAW < 1) ? 1 : ERAL_RAW;
    localparam int WORD_RAW = (CLK_KHZ * WRAL_US / 1000) / DEPTH;
    localparam int WORD_T   = (WORD_RAW < 1) ? 1 : WORD_RAW;
    localparam int MAX_AB   = (ERASE_T > PROG_T) ? ERASE_T : PROG_T;
    localparam int MAX_CD   = (ERAL_T > WORD_T) ? ERAL_T : WORD_T;
    localparam int MAX_T    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W    = $clog2(MAX_T + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
    localparam logic [DATA_W-1:0] ONES      = '1;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] walk;
        logic              we;
        logic              all;
        logic [ADDR_W-1:0] o_addr;
        logic [DATA_W-1:0] o_data;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             busy, accept;
    logic             wel, wel_set, wel_clr;
    prog_op_e         op;
    logic             t_load, t_zero;
    logic [CNT_W-1:0] t_val;

    assign busy   = (r_q.st != ST_IDLE) | r_q.we;
    assign accept = pwr_good_i & ~busy;

    prog_req_arbiter i_arb (
        .accept_i (accept),
        .wel_i    (wel),
        .en_i     (cmd_en_i),
        .dis_i    (cmd_dis_i),
        .wr_i     (cmd_wr_i),
        .eral_i   (cmd_eral_i),
        .wral_i   (cmd_wral_i),
        .set_o    (wel_set),
        .clr_o    (wel_clr),
        .op_o     (op)
    );

    prog_wel_latch i_wel (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (wel_set),
        .clr_i  (wel_clr),
        .kill_i (~pwr_good_i),
        .wel_o  (wel)
    );

    prog_tick_timer #(.CNT_W(CNT_W)) i_tmr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (t_load),
        .load_val_i (t_val),
        .zero_o     (t_zero)
    );

    always_comb begin
        r_d     = r_q;
        r_d.we  = 1'b0;
        r_d.all = 1'b0;
        t_load  = 1'b0;
        t_val   = '0;
        if (!pwr_good_i) begin
            r_d.st = ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    unique case (op)
                        OP_WRITE: begin
                            r_d.st   = ST_WR_ERASE;
                            r_d.addr = addr_i;
                            r_d.data = data_i;
                            t_load   = 1'b1;
                            t_val    = CNT_W'(ERASE_T - 1);
                        end
                        OP_ERAL: begin
                            r_d.st = ST_ERAL;
                            t_load = 1'b1;
                            t_val  = CNT_W'(ERAL_T - 1);
                        end
                        OP_WRAL: begin
                            r_d.st   = ST_WRAL;
                            r_d.data = data_i;
                            r_d.walk = '0;
                            t_load   = 1'b1;
                            t_val    = CNT_W'(WORD_T - 1);
                        end
                        default: ;
                    endcase
                end
                ST_WR_ERASE: begin
                    if (t_zero) begin
                        r_d.we     = 1'b1;
                        r_d.o_addr = r_q.addr;
                        r_d.o_data = ONES;
                        r_d.st     = ST_WR_PROG;
                        t_load     = 1'b1;
                        t_val      = CNT_W'(PROG_T - 1);
                    end
                end
                ST_WR_PROG: begin
                    if (t_zero) begin
                        r_d.we     = 1'b1;
                        r_d.o_addr = r_q.addr;
                        r_d.o_data = r_q.data;
                        r_d.st     = ST_IDLE;
                    end
                end
                ST_ERAL: begin
                    if (t_zero) begin
                        r_d.we     = 1'b1;
                        r_d.all    = 1'b1;
                        r_d.o_addr = '0;
                        r_d.o_data = ONES;
                        r_d.st     = ST_IDLE;
                    end
                end
                ST_WRAL: begin
                    if (t_zero) begin
                        r_d.we     = 1'b1;
                        r_d.o_addr = r_q.walk;
                        r_d.o_data = r_q.data;
                        if (r_q.walk == LAST_ADDR) begin
                            r_d.st = ST_IDLE;
                        end else begin
                            r_d.walk = r_q.walk + 1'b1;
                            t_load   = 1'b1;
                            t_val    = CNT_W'(WORD_T - 1);
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{st: ST_IDLE, default: '0};
        else         r_q <= r_d;
    end

    assign busy_o     = busy;
    assign arr_we_o   = r_q.we;
    assign arr_all_o  = r_q.all;
    assign arr_addr_o = r_q.o_addr;
    assign arr_data_o = r_q.o_data;

endmodule

// File: rtl/prog_seq_checker.sv
module prog_seq_checker
    import prog_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              pwr_good_i,
    input logic              cmd_dis_i,
    input logic              busy_o,
    input logic              arr_we_o,
    input logic              arr_all_o,
    input logic [DATA_W-1:0] arr_data_o,
    input logic              wel,
    input seq_state_e        st,
    input logic              t_zero
);

    // R1: a cycle only starts when permission was held beforehand
    a_r1_start_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(wel));

    // R2: an accepted disable clears the latch
    a_r2_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_dis_i && !busy_o && pwr_good_i) |=> !wel);

    // R4: a timed phase holds its state until its timer expires
    a_r4_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st != ST_IDLE && !t_zero && pwr_good_i) |=> (st == $past(st)));

    // R5: a bulk pulse always writes all ones
    a_r5_eral_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arr_all_o |-> (arr_we_o && (&arr_data_o)));

    // R8: low supply blocks the next pulse
    a_r8_pg_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_good_i |=> !arr_we_o);

    // R8: low supply withdraws permission
    a_r8_pg_clears_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_good_i |=> !wel);

endmodule

bind prog_sequencer prog_seq_checker #(.DATA_W(DATA_W)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .cmd_dis_i  (cmd_dis_i),
    .busy_o     (busy_o),
    .arr_we_o   (arr_we_o),
    .arr_all_o  (arr_all_o),
    .arr_data_o (arr_data_o),
    .wel        (wel),
    .st         (r_q.st),
    .t_zero     (t_zero)
);

// File: tb/test_prog_sequencer.sv
module test_prog_sequencer;

    localparam int AW      = 4;
    localparam int DW      = 16;
    localparam int KHZ     = 8;
    localparam int DEPTH   = 1 << AW;
    localparam int WT      = KHZ * 2000 / 1000;
    localparam int ET      = KHZ * 15000 / 1000;
    localparam int WW      = (KHZ * 15000 / 1000) / DEPTH;
    localparam logic [DW-1:0] ONES = '1;

    localparam logic [4:0] K_EN = 5'b10000, K_DIS = 5'b01000, K_WR = 5'b00100,
                           K_ERAL = 5'b00010, K_WRAL = 5'b00001;

    logic clk = 1'b0, rst_n = 1'b0, pg = 1'b1;
    logic c_en = 0, c_dis = 0, c_wr = 0, c_eral = 0, c_wral = 0;
    logic [AW-1:0] a_in = '0;
    logic [DW-1:0] d_in = '0;
    logic busy, we, all;
    logic [AW-1:0] oa;
    logic [DW-1:0] od;

    always #2.5 clk = ~clk;

    prog_sequencer #(.ADDR_W(AW), .DATA_W(DW), .CLK_KHZ(KHZ),
                     .ERAL_US(15000), .WRAL_US(15000)) i_prog_sequencer (
        .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg),
        .cmd_en_i(c_en), .cmd_dis_i(c_dis), .cmd_wr_i(c_wr),
        .cmd_eral_i(c_eral), .cmd_wral_i(c_wral),
        .addr_i(a_in), .data_i(d_in),
        .busy_o(busy), .arr_we_o(we), .arr_all_o(all),
        .arr_addr_o(oa), .arr_data_o(od));

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] arr [DEPTH];
    logic [DW-1:0] exp_mem [DEPTH];
    bit exp_wel;
    int pcnt;
    logic [AW-1:0] p_addr [32];
    logic [DW-1:0] p_data [32];

    // array model driven only by the block's write port
    always @(posedge clk) begin
        if (we) begin
            if (all) for (int i = 0; i < DEPTH; i++) arr[i] <= od;
            else arr[oa] <= od;
            if (pcnt < 32) begin
                p_addr[pcnt] = oa;
                p_data[pcnt] = od;
            end
            pcnt = pcnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int mem_diff();
        int n = 0;
        for (int i = 0; i < DEPTH; i++) if (arr[i] !== exp_mem[i]) n++;
        return n;
    endfunction

    task automatic do_op(input logic [4:0] k, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output int bc);
        @(negedge clk);
        pcnt = 0;
        {c_en, c_dis, c_wr, c_eral, c_wral} = k;
        a_in = a; d_in = d;
        @(negedge clk);
        {c_en, c_dis, c_wr, c_eral, c_wral} = '0;
        bc = 0;
        while (busy && bc < 5000) begin
            bc++;
            @(negedge clk);
        end
    endtask

    // expected effect of one strobe pattern; returns busy length and pulse count
    task automatic model(input logic [4:0] k, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output int eb, output int ep);
        bit old = exp_wel;
        eb = 0; ep = 0;
        if (k[3]) exp_wel = 0;
        else if (k[4]) exp_wel = 1;
        if (old) begin
            if (k[1]) begin
                for (int i = 0; i < DEPTH; i++) exp_mem[i] = ONES;
                eb = ET + 1; ep = 1;
            end else if (k[0]) begin
                for (int i = 0; i < DEPTH; i++) exp_mem[i] = d;
                eb = DEPTH * WW + 1; ep = DEPTH;
            end else if (k[2]) begin
                exp_mem[a] = d;
                eb = WT + 1; ep = 2;
            end
        end
    endtask

    task automatic run(input logic [4:0] k, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string req);
        int bc, eb, ep;
        model(k, a, d, eb, ep);
        do_op(k, a, d, bc);
        chk(bc == eb, req, "busy length", bc, eb);
        chk(pcnt == ep, req, "pulse count", pcnt, ep);
        chk(mem_diff() == 0, req, "array mismatches", mem_diff(), 0);
        if (ep == 2 && pcnt == 2) begin
            chk(p_data[0] == ONES && p_addr[0] == a, "R3", "erase pulse data",
                p_data[0], ONES);
            chk(p_data[1] == d && p_addr[1] == a, "R3", "data pulse data",
                p_data[1], d);
        end
        if (ep == DEPTH && pcnt == DEPTH)
            for (int i = 0; i < DEPTH; i++)
                chk(p_addr[i] == AW'(i), "R6", "walk order", p_addr[i], i);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int bc, eb, ep;
        void'($urandom(1234));
        for (int i = 0; i < DEPTH; i++) begin
            arr[i] = 16'h5A00 + 16'(i);
            exp_mem[i] = 16'h5A00 + 16'(i);
        end
        exp_wel = 0;
        pcnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1", "busy after reset", busy, 0);
        chk(we == 0, "R1", "pulse after reset", we, 0);
        run(K_WR, 4'd3, 16'h1234, "R1");
        run(K_ERAL, 0, 0, "R1");
        // R2 enable, write, disable
        run(K_EN, 0, 0, "R2");
        run(K_WR, 4'd5, 16'hBEEF, "R4");
        run(K_ERAL, 0, 0, "R5");
        run(K_WRAL, 0, 16'hC3A5, "R6");
        run(K_DIS, 0, 0, "R2");
        run(K_WR, 4'd1, 16'h0F0F, "R2");
        run(K_WRAL, 0, 16'h1111, "R2");
        // R9 priority
        run(K_EN, 0, 0, "R9");
        run(K_EN | K_DIS, 0, 0, "R9");
        run(K_WR, 4'd2, 16'h2222, "R9");
        run(K_EN | K_WR, 4'd2, 16'h3333, "R9");
        run(K_ERAL | K_WRAL | K_WR, 4'd7, 16'h4444, "R9");
        run(K_WRAL | K_WR, 4'd7, 16'h5555, "R9");
        // R7 strobes during busy are dropped
        @(negedge clk);
        pcnt = 0;
        c_wr = 1; a_in = 4'd9; d_in = 16'hAAAA;
        @(negedge clk);
        c_wr = 1; c_dis = 1; a_in = 4'd10; d_in = 16'hBBBB;
        @(negedge clk);
        c_wr = 0; c_dis = 0;
        exp_mem[9] = 16'hAAAA;
        bc = 1;
        while (busy && bc < 5000) begin bc++; @(negedge clk); end
        chk(bc == WT + 1, "R7", "busy length", bc, WT + 1);
        chk(pcnt == 2, "R7", "pulse count", pcnt, 2);
        chk(mem_diff() == 0, "R7", "array mismatches", mem_diff(), 0);
        run(K_WR, 4'd11, 16'hCCCC, "R7");
        // R8 power dip mid-cycle
        @(negedge clk);
        pcnt = 0;
        c_wr = 1; a_in = 4'd12; d_in = 16'hDDDD;
        @(negedge clk);
        c_wr = 0;
        repeat (3) @(negedge clk);
        pg = 0;
        @(negedge clk);
        pg = 1;
        chk(busy == 0, "R8", "busy after dip", busy, 0);
        repeat (WT + 4) @(negedge clk);
        chk(pcnt == 0, "R8", "pulses after dip", pcnt, 0);
        chk(mem_diff() == 0, "R8", "array mismatches", mem_diff(), 0);
        exp_wel = 0;
        run(K_WR, 4'd12, 16'hDDDD, "R8");
        // R8 strobes ignored while supply low
        @(negedge clk);
        pg = 0; c_en = 1;
        @(negedge clk);
        c_en = 0; pg = 1;
        run(K_ERAL, 0, 0, "R8");
        // random mix
        for (int it = 0; it < 40; it++) begin
            int sel = $urandom_range(0, 9);
            logic [4:0] k;
            if (sel < 3) k = K_EN;
            else if (sel < 4) k = K_DIS;
            else if (sel < 8) k = K_WR;
            else if (sel < 9) k = K_ERAL;
            else k = K_WRAL;
            run(k, AW'($urandom()), DW'($urandom()), "R3");
        end
        model(0, 0, 0, eb, ep);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule